// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Bank

This block holds a two-bit state for each of a set of interrupt sources. Bit 1 is P (an event for the source has been sent downstream and waits for an end-of-interrupt). Bit 0 is Q (another trigger arrived while P was set). The bank merges repeated triggers, so a source never has more than one event waiting in the downstream notification path. When software acknowledges a source whose Q bit is set, the bank replays that event.

The block has three interfaces. A trigger input names a source. A memory-mapped load/store port gives each source a 4 KiB page. The source index sits in the address bits above bit 11, and a few special offsets in the page read or overwrite the state and return its previous value. A valid/ready event output carries source indices downstream. Events that wait on a stalled output are held in an internal queue with one slot per source.

Top module: `pq_state_buffer`

## Requirements
- R1: After reset every source is in state PQ=00, `evt_valid` is low and `mmio_rvalid` is low.
- R2: A trigger on a source in state 00 moves it to 10 and emits one event that carries the source index.
- R3: A trigger on a source in state 10 or 11 leaves it in 11 and emits no event.
- R4: A trigger on a source in state 01 (masked) leaves it in 01 and emits no event.
- R5: A store at page offset 0x000 is an end-of-interrupt (EOI). It takes 11 to 10 and emits one event, and it takes 10 to 00 with no event. States 00 and 01 are left unchanged.
- R6: Every load gets a response one cycle later: `mmio_rvalid` is high and `mmio_rdata` holds the result. A load at offset 0x800 returns the state, with P in bit 1, Q in bit 0 and zeros above, and leaves the state unchanged.
- R7: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 return the previous state and set it to 00, 01, 10 and 11 respectively, which is the value of offset bits 9:8. Forcing a state emits no event.
- R8: A load at any other offset returns zero and changes nothing. A store at any offset other than 0x000 changes nothing and gets no response.
- R9: When an MMIO access and a trigger hit the same source in the same cycle, the MMIO operation is applied first and the trigger acts on its result. At most one event results.
- R10: Events leave in the order they were emitted. While `evt_valid` is high and `evt_ready` is low, `evt_valid` stays high and `evt_src` holds its value.
- R11: A source has at most one event held in the queue or presented at the output. An event emitted for a source that already has one outstanding is absorbed. A source's outstanding status is cleared in the cycle its event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger strobe |
| trig_src | input | SRC_W | Source index of the trigger |
| mmio_valid | input | 1 | MMIO access strobe |
| mmio_write | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | SRC_W+12 | Source index in the upper bits, page offset in bits 11:0 |
| mmio_rvalid | output | 1 | Load response valid, one cycle after the load |
| mmio_rdata | output | 64 | Load response data |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Downstream accepts the event |
| evt_src | output | SRC_W | Source index of the event |

## Verification
The bench targets the ways a source can be double-counted or lost:
- A bank that emitted on triggers in states 10, 11 or 01 would leave several events for one source in the queue.
- A bank that cleared Q on an EOI without replaying would lose the trigger that arrived during service.
- Same-cycle collisions of an MMIO force or EOI with a trigger expose a wrong order of operations. The bench then sees the wrong final state or a missing event.
- Forcing a source back to 00 while its old event still waits must not produce a second event.
- Accepting an event in the same cycle that its source fires again must not drop the new event.

// File: rtl/pq_pkg.sv
package pq_pkg;

  // Bit 1 = pending (P), bit 0 = queued (Q)
  typedef logic [1:0] pq_t;

  localparam pq_t PQ_IDLE  = 2'b00;
  localparam pq_t PQ_OFF   = 2'b01;
  localparam pq_t PQ_PEND  = 2'b10;
  localparam pq_t PQ_AGAIN = 2'b11;

  localparam int PAGE_BITS = 12;
  localparam int RDATA_W   = 64;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PEEK,
    OP_FORCE,
    OP_EOI,
    OP_ZERO
  } mmio_op_e;

  typedef struct packed {
    pq_t  state;
    logic fire;
  } step_t;

  function automatic step_t on_trigger(pq_t s);
    step_t r;
    case (s)
      PQ_IDLE:           r = '{state: PQ_PEND,  fire: 1'b1};
      PQ_PEND, PQ_AGAIN: r = '{state: PQ_AGAIN, fire: 1'b0};
      default:           r = '{state: PQ_OFF,   fire: 1'b0};
    endcase
    return r;
  endfunction

  function automatic step_t on_eoi(pq_t s);
    step_t r;
    case (s)
      PQ_AGAIN: r = '{state: PQ_PEND, fire: 1'b1};
      PQ_PEND:  r = '{state: PQ_IDLE, fire: 1'b0};
      default:  r = '{state: s,       fire: 1'b0};
    endcase
    return r;
  endfunction

  function automatic step_t on_force(pq_t v);
    step_t r;
    r = '{state: v, fire: 1'b0};
    return r;
  endfunction

endpackage

// File: rtl/pq_mmio_decode.sv
module pq_mmio_decode
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = 4,
  localparam int ADDR_W = SRC_W + PAGE_BITS
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output mmio_op_e          op,
  output logic [SRC_W-1:0]  src,
  output pq_t               force_val,
  output logic              hit,
  output logic              is_read
);

  logic [PAGE_BITS-1:0] offs;
  logic                 in_range;
  logic                 force_slot;

  always_comb begin
    offs       = acc_addr[PAGE_BITS-1:0];
    src        = acc_addr[ADDR_W-1:PAGE_BITS];
    in_range   = int'(src) < NUM_SRC;
    force_slot = (offs[11:10] == 2'b11) && (offs[7:0] == 8'h00);
    force_val  = offs[9:8];
    is_read    = acc_valid && !acc_write;

    op = OP_NONE;
    if (acc_valid) begin
      if (acc_write) begin
        if (offs == '0) op = OP_EOI;
      end else if (offs == 12'h800) begin
        op = OP_PEEK;
      end else if (force_slot) begin
        op = OP_FORCE;
      end else begin
        op = OP_ZERO;
      end
    end
    hit = in_range && (op == OP_PEEK || op == OP_FORCE || op == OP_EOI);
  end

endmodule

// File: rtl/pq_source_bank.sv
module pq_source_bank
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mmio_op_e         m_op,
  input  logic             m_ok,
  input  logic [SRC_W-1:0] m_src,
  input  pq_t              m_force,
  input  logic             t_ok,
  input  logic [SRC_W-1:0] t_src,
  output pq_t              m_prev,
  output logic             fire_m,
  output logic             fire_t
);

  pq_t                pq_q [NUM_SRC];
  pq_t                pq_d [NUM_SRC];
  logic [NUM_SRC-1:0] upd_en;
  logic               same;
  step_t              m_res;
  step_t              t_res;
  pq_t                mid;

  // MMIO result first, trigger applied on top of it
  always_comb begin
    same   = m_ok && t_ok && (m_src == t_src);
    m_prev = pq_q[m_src];
    m_res  = '{state: m_prev, fire: 1'b0};
    if (m_ok) begin
      case (m_op)
        OP_FORCE: m_res = on_force(m_force);
        OP_EOI:   m_res = on_eoi(m_prev);
        default:  m_res = '{state: m_prev, fire: 1'b0};
      endcase
    end
    mid    = same ? m_res.state : pq_q[t_src];
    t_res  = on_trigger(mid);
    fire_m = (m_ok && m_res.fire) || (same && t_res.fire);
    fire_t = t_ok && !same && t_res.fire;
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      pq_d[i]   = pq_q[i];
      upd_en[i] = 1'b0;
      if (m_ok && int'(m_src) == i) begin
        pq_d[i]   = m_res.state;
        upd_en[i] = 1'b1;
      end
      if (t_ok && int'(t_src) == i) begin
        pq_d[i]   = t_res.state;
        upd_en[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) pq_q[i] <= PQ_IDLE;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (upd_en[i]) pq_q[i] <= pq_d[i];
      end
    end
  end

  // R4: a masked source ignores a trigger
  p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (t_ok && !same && pq_q[t_src] == PQ_OFF) |=> (pq_q[$past(t_src)] == PQ_OFF));

  // R5: EOI on 11 leaves the source pending
  p_eoi_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ok && m_op == OP_EOI && !same && pq_q[m_src] == PQ_AGAIN)
      |=> (pq_q[$past(m_src)] == PQ_PEND));

  // R2: an idle source that is triggered becomes pending
  p_idle_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_ok && !same && pq_q[t_src] == PQ_IDLE) |=> (pq_q[$past(t_src)] == PQ_PEND));

  // R3: a pending source never returns to idle on a trigger
  p_coalesce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (t_ok && !same && pq_q[t_src][1]) |=> (pq_q[$past(t_src)] == PQ_AGAIN));

endmodule

// File: rtl/pq_event_queue.sv
module pq_event_queue #(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = 4,
  localparam int DEPTH  = NUM_SRC,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_a,
  input  logic [SRC_W-1:0] src_a,
  input  logic             req_b,
  input  logic [SRC_W-1:0] src_b,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SRC_W-1:0] out_src
);

  logic [SRC_W-1:0]   mem [DEPTH];
  logic [PTR_W-1:0]   rd_q, rd_d, wr_q, wr_d, wr_b;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [NUM_SRC-1:0] busy_q, busy_d;
  logic               pop, busy_a, busy_b, acc_a, acc_b;

  function automatic logic [PTR_W-1:0] ptr_add(logic [PTR_W-1:0] p, int k);
    int t;
    t = int'(p) + k;
    if (t >= DEPTH) t = t - DEPTH;
    return PTR_W'(t);
  endfunction

  always_comb begin
    out_valid = (cnt_q != '0);
    out_src   = mem[rd_q];
    pop       = out_valid && out_ready;
    // a source whose event leaves this cycle may queue a new one at once
    busy_a    = busy_q[src_a] && !(pop && out_src == src_a);
    busy_b    = busy_q[src_b] && !(pop && out_src == src_b);
    acc_a     = req_a && !busy_a;
    acc_b     = req_b && !busy_b && !(acc_a && src_a == src_b);
    wr_b      = acc_a ? ptr_add(wr_q, 1) : wr_q;
    wr_d      = ptr_add(wr_q, int'(acc_a) + int'(acc_b));
    rd_d      = pop ? ptr_add(rd_q, 1) : rd_q;
    cnt_d     = CNT_W'(int'(cnt_q) + int'(acc_a) + int'(acc_b) - int'(pop));
    busy_d    = busy_q;
    if (pop)   busy_d[out_src] = 1'b0;
    if (acc_a) busy_d[src_a]   = 1'b1;
    if (acc_b) busy_d[src_b]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  // data array: written only, never reset
  always_ff @(posedge clk) begin
    if (acc_a) mem[wr_q] <= src_a;
    if (acc_b) mem[wr_b] <= src_b;
  end

  // R11: one slot per source is always enough
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) + int'(acc_a) + int'(acc_b) - int'(pop)) <= DEPTH);

  // R11: an outstanding source is never queued twice
  p_single_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_a && acc_b) |-> (src_a != src_b));

  // R10: a stalled event holds
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src)));

endmodule

// File: rtl/pq_state_buffer.sv
module pq_state_buffer
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W = SRC_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [SRC_W-1:0]   trig_src,
  input  logic               mmio_valid,
  input  logic               mmio_write,
  input  logic [ADDR_W-1:0]  mmio_addr,
  output logic               mmio_rvalid,
  output logic [RDATA_W-1:0] mmio_rdata,
  output logic               evt_valid,
  input  logic               evt_ready,
  output logic [SRC_W-1:0]   evt_src
);

  logic               rst_meta, rst_sync_n;
  mmio_op_e           op;
  logic [SRC_W-1:0]   m_src;
  pq_t                m_force, m_prev;
  logic               m_hit, m_read, t_ok, fire_m, fire_t;
  logic               rv_d;
  logic [RDATA_W-1:0] rd_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pq_mmio_decode #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) dec_i (
    .acc_valid (mmio_valid),
    .acc_write (mmio_write),
    .acc_addr  (mmio_addr),
    .op        (op),
    .src       (m_src),
    .force_val (m_force),
    .hit       (m_hit),
    .is_read   (m_read)
  );

  always_comb t_ok = trig_valid && (int'(trig_src) < NUM_SRC);

  pq_source_bank #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) bank_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .m_op    (op),
    .m_ok    (m_hit),
    .m_src   (m_src),
    .m_force (m_force),
    .t_ok    (t_ok),
    .t_src   (trig_src),
    .m_prev  (m_prev),
    .fire_m  (fire_m),
    .fire_t  (fire_t)
  );

  pq_event_queue #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) queue_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_a     (fire_m),
    .src_a     (m_src),
    .req_b     (fire_t),
    .src_b     (trig_src),
    .out_ready (evt_ready),
    .out_valid (evt_valid),
    .out_src   (evt_src)
  );

  always_comb begin
    rv_d = m_read;
    rd_d = '0;
    if (m_hit && (op == OP_PEEK || op == OP_FORCE)) rd_d = {{(RDATA_W-2){1'b0}}, m_prev};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mmio_rvalid <= 1'b0;
      mmio_rdata  <= '0;
    end else begin
      mmio_rvalid <= rv_d;
      if (rv_d) mmio_rdata <= rd_d;
    end
  end

  // R6: every load is answered in the next cycle
  p_read_answer_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mmio_valid && !mmio_write) |=> mmio_rvalid);

  // R8: stores never produce a response
  p_write_silent_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mmio_valid || mmio_write) |=> !mmio_rvalid);

  // R6: only the two low bits of a response can be set
  p_rdata_narrow_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mmio_rvalid |-> (mmio_rdata[RDATA_W-1:2] == '0));

endmodule

// File: tb/pq_state_buffer_tb_top.sv
module pq_state_buffer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 16;
  localparam int SRC_W      = 4;
  localparam int ADDR_W     = SRC_W + 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trig_valid = 1'b0;
  logic [SRC_W-1:0]  trig_src = '0;
  logic              mmio_valid = 1'b0;
  logic              mmio_write = 1'b0;
  logic [ADDR_W-1:0] mmio_addr = '0;
  logic              mmio_rvalid;
  logic [63:0]       mmio_rdata;
  logic              evt_valid;
  logic              evt_ready = 1'b0;
  logic [SRC_W-1:0]  evt_src;

  int n_chk = 0;
  int n_fail = 0;
  int pq_m [NUM_SRC];
  bit busy_m [NUM_SRC];
  int q_m [$];
  bit exp_rv;
  longint exp_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pq_state_buffer #(.NUM_SRC(NUM_SRC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_src(trig_src),
    .mmio_valid(mmio_valid), .mmio_write(mmio_write), .mmio_addr(mmio_addr),
    .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_src(evt_src)
  );

  function automatic int trig_next(int s);
    if (s == 0) return 2;
    if (s >= 2) return 3;
    return s;
  endfunction
  function automatic bit trig_fires(int s); return s == 0; endfunction
  function automatic int eoi_next(int s);
    if (s == 3) return 2;
    if (s == 2) return 0;
    return s;
  endfunction
  function automatic bit eoi_fires(int s); return s == 3; endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] addr_of(int src, int off);
    return ADDR_W'(src * 4096 + off);
  endfunction

  task automatic push_ev(int s);
    if (!busy_m[s]) begin
      q_m.push_back(s);
      busy_m[s] = 1'b1;
    end
  endtask

  task automatic step(bit tv, int ts, bit mv, bit mw, int msrc, int moff, bit rdy, string tag);
    bit fm, ft;
    @(negedge clk);
    trig_valid = tv; trig_src = SRC_W'(ts);
    mmio_valid = mv; mmio_write = mw; mmio_addr = addr_of(msrc, moff);
    evt_ready  = rdy;
    @(posedge clk);
    if (rdy && q_m.size() > 0) begin
      busy_m[q_m[0]] = 1'b0;
      void'(q_m.pop_front());
    end
    exp_rv = 1'b0; fm = 1'b0; ft = 1'b0;
    if (mv) begin
      if (!mw) begin
        exp_rv = 1'b1; exp_rd = 0;
        if (moff == 'h800) exp_rd = pq_m[msrc];
        else if (moff == 'hC00 || moff == 'hD00 || moff == 'hE00 || moff == 'hF00) begin
          exp_rd = pq_m[msrc];
          pq_m[msrc] = (moff >> 8) & 3;
        end
      end else if (moff == 0) begin
        fm = eoi_fires(pq_m[msrc]);
        pq_m[msrc] = eoi_next(pq_m[msrc]);
      end
    end
    if (tv) begin
      ft = trig_fires(pq_m[ts]);
      pq_m[ts] = trig_next(pq_m[ts]);
    end
    if (mv && tv && ts == msrc) begin fm = fm | ft; ft = 1'b0; end
    if (fm) push_ev(msrc);
    if (ft) push_ev(ts);
    #1;
    chk(evt_valid == (q_m.size() > 0), tag, "evt_valid", longint'(evt_valid), longint'(q_m.size() > 0));
    if (q_m.size() > 0) chk(int'(evt_src) == q_m[0], tag, "evt_src", longint'(evt_src), longint'(q_m[0]));
    chk(mmio_rvalid == exp_rv, tag, "mmio_rvalid", longint'(mmio_rvalid), longint'(exp_rv));
    if (exp_rv) chk(mmio_rdata == 64'(exp_rd), tag, "mmio_rdata", longint'(mmio_rdata), exp_rd);
  endtask

  task automatic idle(bit rdy, string tag);
    step(1'b0, 0, 1'b0, 1'b0, 0, 0, rdy, tag);
  endtask
  task automatic peek(int s, string tag);
    step(1'b0, 0, 1'b1, 1'b0, s, 'h800, 1'b0, tag);
  endtask
  task automatic trig(int s, string tag);
    step(1'b1, s, 1'b0, 1'b0, 0, 0, 1'b0, tag);
  endtask
  task automatic mload(int s, int off, string tag);
    step(1'b0, 0, 1'b1, 1'b0, s, off, 1'b0, tag);
  endtask
  task automatic eoi(int s, string tag);
    step(1'b0, 0, 1'b1, 1'b1, s, 0, 1'b0, tag);
  endtask
  task automatic drain(string tag);
    for (int i = 0; i < NUM_SRC + 2; i++) idle(1'b1, tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int offs [7];
    offs = '{0, 'h800, 'hC00, 'hD00, 'hE00, 'hF00, 'h124};
    void'($urandom(32'd4242));
    for (int i = 0; i < NUM_SRC; i++) begin pq_m[i] = 0; busy_m[i] = 1'b0; end
    exp_rv = 1'b0; exp_rd = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(evt_valid == 1'b0, "R1", "evt_valid", longint'(evt_valid), 0);
    chk(mmio_rvalid == 1'b0, "R1", "mmio_rvalid", longint'(mmio_rvalid), 0);
    for (int i = 0; i < NUM_SRC; i++) peek(i, "R1");

    trig(3, "R2");
    peek(3, "R2");
    trig(3, "R3");
    trig(3, "R3");
    peek(3, "R3");
    mload(3, 'hC00, "R7");          // back to 00, event still waiting
    trig(3, "R11");                  // fires but is absorbed
    peek(3, "R11");
    trig(5, "R10");
    trig(7, "R10");
    idle(1'b0, "R10");
    drain("R10");

    trig(4, "R5");
    trig(4, "R5");                   // 11
    drain("R5");
    eoi(4, "R5");                    // 11 -> 10, replay
    peek(4, "R5");
    eoi(4, "R5");                    // 10 -> 00
    eoi(4, "R5");                    // 00 stays
    peek(4, "R5");
    drain("R5");

    mload(9, 'hD00, "R7");
    trig(9, "R4");
    peek(9, "R4");
    eoi(9, "R5");
    peek(9, "R5");
    mload(9, 'hF00, "R7");
    mload(9, 'hE00, "R7");
    peek(9, "R6");

    mload(2, 'h124, "R8");
    mload(2, 'h804, "R8");
    step(1'b0, 0, 1'b1, 1'b1, 2, 'h800, 1'b0, "R8");
    step(1'b0, 0, 1'b1, 1'b1, 2, 'hC00, 1'b0, "R8");
    peek(2, "R8");

    trig(6, "R9");                   // 10, event queued
    drain("R9");
    step(1'b1, 6, 1'b1, 1'b0, 6, 'hC00, 1'b0, "R9");   // force 00 then trigger
    peek(6, "R9");
    trig(6, "R9");                   // 11
    drain("R9");
    step(1'b1, 6, 1'b1, 1'b1, 6, 0, 1'b0, "R9");       // EOI replays, trigger sets Q
    peek(6, "R9");

    trig(8, "R11");
    step(1'b0, 0, 1'b1, 1'b0, 8, 'hC00, 1'b0, "R11");
    step(1'b1, 8, 1'b0, 1'b0, 0, 0, 1'b1, "R11");      // accepted and re-fired together
    drain("R11");

    for (int n = 0; n < 4000; n++) begin
      bit tv, mv, mw, rdy;
      int ts, ms, off;
      tv  = ($urandom % 3) == 0;
      ts  = $urandom % NUM_SRC;
      mv  = ($urandom % 3) == 0;
      mw  = ($urandom % 2) == 0;
      ms  = ($urandom % 4 == 0) ? ts : ($urandom % NUM_SRC);
      off = offs[$urandom % 7];
      rdy = ($urandom % 4) != 0;
      step(tv, ts, mv, mw, ms, off, rdy, "R10");
    end
    drain("R10");
    summary();
  end

endmodule